// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Conditions

This block is a 32-pin general-purpose I/O controller reached through a plain 32-bit register port. The port has an address, a write strobe, write data and read data. Software sets the value each pin drives and the pin's direction. It can read back the level seen on every pad. Each pad passes through a two-stage synchroniser, and the synchronised level is what the status register and the event logic see.

Each pin has its own interrupt trigger: low level, high level, rising edge, falling edge, or either edge. A trigger event sets the pin's bit in a sticky status register, and software clears that bit by writing a one to it. A mask register decides which status bits may reach the two interrupt lines. The first line serves pins 0 to 15 and the second serves pins 16 to 31.

Reads return data one clock after the address is presented. The data, direction and interrupt outputs all come straight from flops.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero, and `pad_oe`, `pad_out` and `irq` are all zero.
- R2: Offset 0x00 holds the drive value and offset 0x04 holds the direction. A direction bit of 1 makes the pin an output: `pad_oe` equals the direction register and `pad_out` equals the drive register. Both registers read back what was written.
- R3: Offset 0x08 returns the pads after a two-flop synchroniser, whatever each pin's direction. A read at this offset returns the value `pad_in` had three clock edges before the read data is sampled. Writes to this offset are ignored.
- R4: Each pin has a 2-bit trigger code: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Pin n < 16 takes its code from bits [2n+1:2n] of offset 0x0C. Pin n ≥ 16 takes its code from bits [2(n-16)+1:2(n-16)] of offset 0x10.
- R5: An edge is a change between two consecutive synchronised samples. A rising-coded pin latches only on 0→1, and a falling-coded pin latches only on 1→0.
- R6: Offset 0x1C holds one both-edge bit per pin. When a pin's bit is set, the pin latches on both edges and its 2-bit trigger code is ignored.
- R7: Offset 0x18 is the sticky event status. Writing 1 to a bit clears that bit, and writing 0 leaves it unchanged.
- R8: While a level condition holds, its status bit is set again every cycle. When a clear and an event land in the same cycle, the event wins.
- R9: Offset 0x14 is the mask. `irq[0]` is the registered OR of (status & mask) over pins 0–15, and `irq[1]` is the same over pins 16–31. With the mask at zero, both lines stay low.
- R10: A read of any other offset, including misaligned ones, returns zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address of register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, one cycle after addr |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Drive value per pin |
| pad_oe | output | 32 | Output enable per pin (1 = output) |
| irq | output | 2 | Interrupt lines for pins 0–15 and 16–31 |

## Verification
Faults in the synchroniser or the previous-sample flop show up as events that appear too early, too late or twice. These are visible in the status register three to four cycles after a pad change. A fault in the trigger-code decode sets the wrong status bit, so each code is tested on pins chosen so that a swap between the two configuration words, or between neighbouring fields, changes the value read back. Faults in the clear path or the event priority show up as a status bit that survives or vanishes in the read that follows a one-cycle clear. A faulty mask or group split shows up on `irq` two clocks after the mask write.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int GPIO_AW = 5;

  localparam logic [GPIO_AW-1:0] OFF_DOUT  = 5'h00;
  localparam logic [GPIO_AW-1:0] OFF_DIR   = 5'h04;
  localparam logic [GPIO_AW-1:0] OFF_PAD   = 5'h08;
  localparam logic [GPIO_AW-1:0] OFF_CFGLO = 5'h0C;
  localparam logic [GPIO_AW-1:0] OFF_CFGHI = 5'h10;
  localparam logic [GPIO_AW-1:0] OFF_MASK  = 5'h14;
  localparam logic [GPIO_AW-1:0] OFF_STS   = 5'h18;
  localparam logic [GPIO_AW-1:0] OFF_BOTH  = 5'h1C;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  function automatic logic addr_known(input logic [GPIO_AW-1:0] a);
    return (a == OFF_DOUT) || (a == OFF_DIR) || (a == OFF_PAD) ||
           (a == OFF_CFGLO) || (a == OFF_CFGHI) || (a == OFF_MASK) ||
           (a == OFF_STS) || (a == OFF_BOTH);
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_ctrl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] cfg_lo,
  input  logic [N-1:0] cfg_hi,
  input  logic [N-1:0] both,
  output logic [N-1:0] ev
);
  localparam int HALF = N / 2;

  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  for (genvar n = 0; n < N; n++) begin : g_pin
    logic [1:0] code;
    logic       rise, fall;

    if (n < HALF) begin : g_lo
      assign code = cfg_lo[2*n +: 2];
    end else begin : g_hi
      assign code = cfg_hi[2*(n-HALF) +: 2];
    end

    assign rise = lvl[n] & ~prev[n];
    assign fall = ~lvl[n] & prev[n];

    always_comb begin
      if (both[n]) begin
        ev[n] = rise | fall;
      end else begin
        case (trig_e'(code))
          TRIG_LOW:  ev[n] = ~lvl[n];
          TRIG_HIGH: ev[n] = lvl[n];
          TRIG_RISE: ev[n] = rise;
          default:   ev[n] = fall;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int N      = 32,
  parameter int GROUPS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      sts,
  input  logic [N-1:0]      mask,
  output logic [GROUPS-1:0] irq
);
  localparam int GW = N / GROUPS;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) irq[g] <= 1'b0;
      else     irq[g] <= |(sts[g*GW +: GW] & mask[g*GW +: GW]);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_LINES   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GPIO_AW-1:0]   addr,
  input  logic                 wr_en,
  input  logic [NUM_PINS-1:0]  wdata,
  output logic [NUM_PINS-1:0]  rdata,
  input  logic [NUM_PINS-1:0]  pad_in,
  output logic [NUM_PINS-1:0]  pad_out,
  output logic [NUM_PINS-1:0]  pad_oe,
  output logic [IRQ_LINES-1:0] irq
);
  logic [NUM_PINS-1:0] dout_q, dir_q, cfglo_q, cfghi_q, mask_q, sts_q, both_q;
  logic [NUM_PINS-1:0] pad_sync, evt;
  logic [NUM_PINS-1:0] clr_bits;

  gpio_pad_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_sync)
  );

  gpio_evt_detect #(.N(NUM_PINS)) u_evt (
    .clk(clk), .rst(rst), .lvl(pad_sync),
    .cfg_lo(cfglo_q), .cfg_hi(cfghi_q), .both(both_q), .ev(evt)
  );

  gpio_irq_merge #(.N(NUM_PINS), .GROUPS(IRQ_LINES)) u_merge (
    .clk(clk), .rst(rst), .sts(sts_q), .mask(mask_q), .irq(irq)
  );

  assign clr_bits = (wr_en && addr == OFF_STS) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dir_q   <= '0;
      cfglo_q <= '0;
      cfghi_q <= '0;
      mask_q  <= '0;
      both_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_DOUT:  dout_q  <= wdata;
        OFF_DIR:   dir_q   <= wdata;
        OFF_CFGLO: cfglo_q <= wdata;
        OFF_CFGHI: cfghi_q <= wdata;
        OFF_MASK:  mask_q  <= wdata;
        OFF_BOTH:  both_q  <= wdata;
        default:   ;
      endcase
    end
  end

  // events take priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= (sts_q & ~clr_bits) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        OFF_DOUT:  rdata <= dout_q;
        OFF_DIR:   rdata <= dir_q;
        OFF_PAD:   rdata <= pad_sync;
        OFF_CFGLO: rdata <= cfglo_q;
        OFF_CFGHI: rdata <= cfghi_q;
        OFF_MASK:  rdata <= mask_q;
        OFF_STS:   rdata <= sts_q;
        OFF_BOTH:  rdata <= both_q;
        default:   rdata <= '0;
      endcase
    end
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter int IRQ_LINES = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [GPIO_AW-1:0]   addr,
  input logic                 wr_en,
  input logic [NUM_PINS-1:0]  wdata,
  input logic [NUM_PINS-1:0]  rdata,
  input logic [NUM_PINS-1:0]  pad_in,
  input logic [NUM_PINS-1:0]  pad_out,
  input logic [NUM_PINS-1:0]  pad_oe,
  input logic [IRQ_LINES-1:0] irq,
  input logic [NUM_PINS-1:0]  sts,
  input logic [NUM_PINS-1:0]  ev,
  input logic [NUM_PINS-1:0]  mask
);
  logic [3:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)              cyc <= '0;
    else if (cyc != 4'hF) cyc <= cyc + 4'd1;
  end

  assert_reset_outputs_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && irq == '0));

  assert_pad_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4'd4 && $past(addr) == OFF_PAD) |-> rdata == $past(pad_in, 3));

  assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_STS && ev == '0) |=> sts == ($past(sts) & ~$past(wdata)));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((sts & $past(ev)) == $past(ev)));

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> (irq == '0));

  assert_idle_status_R9: assert property (@(posedge clk) disable iff (rst)
    (sts == '0) |=> (irq == '0));

  assert_unknown_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4'd1 && !addr_known($past(addr))) |-> rdata == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .IRQ_LINES(IRQ_LINES)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .irq(irq), .sts(sts_q), .ev(evt), .mask(mask_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  import gpio_ctrl_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [1:0]  irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  logic rd_req = 1'b0;
  logic rd_pend = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares each read result against the queued expectation
  always @(posedge clk) rd_pend <= rd_req;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL scoreboard got %h expected none", rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr   = a;
    wr_en  = 1'b0;
    rd_req = 1'b1;
    sb_q.push_back('{exp: e, tag: tag});
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pads(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", {30'h0, irq}, 32'h0);
    rd(OFF_DOUT, 32'h0, "R1 dout");
    rd(OFF_DIR, 32'h0, "R1 dir");
    rd(OFF_MASK, 32'h0, "R1 mask");
    rd(OFF_CFGLO, 32'h0, "R1 cfglo");
    rd(OFF_BOTH, 32'h0, "R1 both");
    // R4 default code 0 = low level, pads are low
    rd(OFF_STS, 32'hFFFF_FFFF, "R4 low level all pins");

    // R2 drive and direction
    wr(OFF_DOUT, 32'hA5A5_1234);
    wr(OFF_DIR, 32'h0000_FFFF);
    chk("R2 pad_out", pad_out, 32'hA5A5_1234);
    chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    rd(OFF_DOUT, 32'hA5A5_1234, "R2 dout readback");
    rd(OFF_DIR, 32'h0000_FFFF, "R2 dir readback");

    // R3 pad status regardless of direction; writes ignored
    pads(32'h1234_5678);
    rd(OFF_PAD, 32'h1234_5678, "R3 pad status");
    wr(OFF_PAD, 32'h0);
    rd(OFF_PAD, 32'h1234_5678, "R3 write ignored");

    // configure: pin0 high, pin1 rise, pin2 fall, pin3 low, others rise; pin17 both
    pads(32'h0);
    wr(OFF_CFGLO, 32'hAAAA_AA39);
    wr(OFF_CFGHI, 32'hAAAA_AAAA);
    wr(OFF_BOTH, 32'h0002_0000);
    rd(OFF_CFGLO, 32'hAAAA_AA39, "R4 cfglo readback");
    rd(OFF_BOTH, 32'h0002_0000, "R6 both readback");
    wr(OFF_STS, 32'hFFFF_FFFF);
    rd(OFF_STS, 32'h0000_0008, "R8 low level survives clear");

    // R5 rising on pin1 and pin16
    pads(32'h0001_0002);
    rd(OFF_STS, 32'h0001_000A, "R5 rising");
    // R7 write one clears, zero bits untouched
    wr(OFF_STS, 32'h0000_0002);
    rd(OFF_STS, 32'h0001_0008, "R7 w1c");
    wr(OFF_STS, 32'h0000_0000);
    rd(OFF_STS, 32'h0001_0008, "R7 zero write no effect");

    // R5 falling-coded pin2 ignores rise, latches fall
    pads(32'h0001_0006);
    rd(OFF_STS, 32'h0001_0008, "R5 fall ignores rise");
    pads(32'h0001_0000);
    rd(OFF_STS, 32'h0001_000C, "R5 falling");

    // R4/R8 high level on pin0 persists through a clear
    pads(32'h0001_0001);
    rd(OFF_STS, 32'h0001_000D, "R4 high level");
    wr(OFF_STS, 32'h0000_0001);
    rd(OFF_STS, 32'h0001_000D, "R8 level reasserts");
    pads(32'h0001_0000);
    wr(OFF_STS, 32'h0000_0001);
    rd(OFF_STS, 32'h0001_000C, "R8 cleared after level ends");

    // R6 both edges on pin17 (code says rising)
    pads(32'h0003_0000);
    rd(OFF_STS, 32'h0003_000C, "R6 both rise");
    wr(OFF_STS, 32'h0002_0000);
    rd(OFF_STS, 32'h0001_000C, "R6 cleared");
    pads(32'h0001_0000);
    rd(OFF_STS, 32'h0003_000C, "R6 both fall");

    // R4 upper word field: pin20 high level via bits [9:8] of 0x10
    wr(OFF_CFGHI, 32'hAAAA_A9AA);
    pads(32'h0011_0000);
    rd(OFF_STS, 32'h0013_000C, "R4 upper config field");

    // R9 mask and group split
    chk("R9 irq masked", {30'h0, irq}, 32'h0);
    wr(OFF_MASK, 32'h0000_0004);
    @(negedge clk);
    chk("R9 irq low group", {30'h0, irq}, 32'h1);
    wr(OFF_MASK, 32'h0002_0000);
    @(negedge clk);
    chk("R9 irq high group", {30'h0, irq}, 32'h2);
    wr(OFF_MASK, 32'h0000_0001);
    @(negedge clk);
    chk("R9 irq unset bit masked", {30'h0, irq}, 32'h0);
    wr(OFF_MASK, 32'h0000_0004);
    @(negedge clk);
    chk("R9 irq reasserted", {30'h0, irq}, 32'h1);
    wr(OFF_STS, 32'h0000_0004);
    @(negedge clk);
    chk("R9 irq drops on clear", {30'h0, irq}, 32'h0);

    // R10 undefined offsets
    rd(5'h1D, 32'h0, "R10 misaligned read");
    rd(5'h02, 32'h0, "R10 misaligned read low");
    wr(5'h1D, 32'hFFFF_FFFF);
    wr(5'h16, 32'hFFFF_FFFF);
    rd(OFF_MASK, 32'h0000_0004, "R10 mask untouched");
    rd(OFF_DOUT, 32'hA5A5_1234, "R10 dout untouched");
    rd(OFF_BOTH, 32'h0002_0000, "R10 both untouched");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL scoreboard got %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule